// File: doc/BRIEF.md
# Byte-Indexed Table Lookup Unit

This block assembles a 32-bit word one byte at a time by lookup. The index word carries four independent 8-bit indices, one per byte lane. Each index picks a byte out of a small table of four 64-bit entries. If an index falls outside a caller-supplied limit, its lane takes the matching byte of a default word. The four lanes are evaluated in parallel by combinational logic.

The table is held in registers. It is loaded through a synchronous single-entry write port and is cleared by reset. A datapath that permutes bytes, or translates them through a table, drives the index, default and limit inputs and takes the result in the same cycle.

Top module: `byte_table_lookup`

## Requirements
- R1: Lane k (k = 0..3) takes its index from `idx_word[8k+7:8k]` and places its byte at `result[8k+7:8k]`. The lanes are independent of one another.
- R2: A lane index is in range only when it is strictly less than `limit` and also less than 32, the table capacity in bytes. An index of 32 or more is out of range for every limit, 255 included.
- R3: For an in-range index v, the lane byte is byte `v[2:0]` of table entry `v[4:3]`. Byte b of an entry occupies its bits `[8b+7:8b]`.
- R4: For an out-of-range index, the lane byte equals `dflt_word` at the same lane position.
- R5: `result` follows `idx_word`, `dflt_word` and `limit` combinationally, with no clock edge in between.
- R6: When `wr_en` is high at a rising clock edge, entry `wr_addr` takes `wr_data`. The other entries keep their contents.
- R7: While `rst_n` is low (asynchronous, active low), every table entry is zero, so every in-range lookup returns 0.
- R8: With `limit` equal to 0, every lane returns its default byte.
- R9: A rising clock edge with `wr_en` low leaves the whole table unchanged, whatever `wr_addr` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the table write port |
| rst_n | input | 1 | Asynchronous active-low reset; clears the table |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 2 | Entry written when `wr_en` is high |
| wr_data | input | 64 | Data written into the entry |
| idx_word | input | 32 | Four packed 8-bit lane indices |
| dflt_word | input | 32 | Default bytes for out-of-range lanes |
| limit | input | 8 | Exclusive upper bound on valid indices |
| result | output | 32 | Assembled lookup word |

## Verification
The table is loaded with a distinct value in every byte. Index bytes 0 to 255 are then swept through all four lanes, each lane with its own offset, under the limits 0, 8, 16, 24, 32, 40 and 255.

- The in-range vectors show that the entry and byte selection is correct, since every byte of the table is different.
- The limits of 40 and 255 show that the capacity bound of 32 holds even when the limit would admit a larger index.
- A limit of 0 shows that every lane takes its default byte.
- Default words that change on every vector confirm that each out-of-range lane copies its own lane's default byte.

Three further tests cover the write port and reset:

- A lookup during reset checks that the table reads zero.
- A cycle with the enable low checks that a write request is ignored.
- Rewriting one entry checks that the other three entries keep their contents.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  localparam int BYTE_W = 8;

  // Lane is valid when below both the caller limit and the table capacity.
  function automatic logic lane_in_range(input logic [BYTE_W-1:0] idx,
                                         input logic [BYTE_W-1:0] lim,
                                         input int unsigned cap);
    return (idx < lim) && (32'(idx) < cap);
  endfunction

  // Choose between the looked-up byte and the default byte.
  function automatic logic [BYTE_W-1:0] merge_lane(input logic ok,
                                                   input logic [BYTE_W-1:0] picked,
                                                   input logic [BYTE_W-1:0] dflt);
    return ok ? picked : dflt;
  endfunction
endpackage

// File: rtl/tlu_table_store.sv
module tlu_table_store #(
  parameter int NUM_ENTRIES = 4,
  parameter int ENTRY_W     = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [$clog2(NUM_ENTRIES)-1:0]  wr_addr,
  input  logic [ENTRY_W-1:0]              wr_data,
  output logic [NUM_ENTRIES*ENTRY_W-1:0]  table_flat
);
  localparam int ADDR_W = $clog2(NUM_ENTRIES);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [ENTRY_W-1:0] ent_q;
    logic               hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q <= '0;
      else if (hit) ent_q <= wr_data;
    end
    assign table_flat[e*ENTRY_W +: ENTRY_W] = ent_q;
  end
endmodule

// File: rtl/tlu_lane_pick.sv
module tlu_lane_pick
  import tlu_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ENTRY_W     = 64
) (
  input  logic [BYTE_W-1:0]               idx_byte,
  input  logic [BYTE_W-1:0]               dflt_byte,
  input  logic [BYTE_W-1:0]               limit,
  input  logic [NUM_ENTRIES*ENTRY_W-1:0]  table_flat,
  output logic [BYTE_W-1:0]               lane_byte,
  output logic                            lane_ok
);
  localparam int BPE   = ENTRY_W / BYTE_W;
  localparam int CAP   = NUM_ENTRIES * BPE;
  localparam int IDX_W = $clog2(CAP);
  localparam int SEL_W = $clog2(BPE);

  logic [BYTE_W-1:0] picked;
  int unsigned       ent;
  int unsigned       sel;

  always_comb begin
    lane_ok   = lane_in_range(idx_byte, limit, CAP);
    ent       = 32'(idx_byte[IDX_W-1:SEL_W]);
    sel       = 32'(idx_byte[SEL_W-1:0]);
    picked    = table_flat[ent*ENTRY_W + sel*BYTE_W +: BYTE_W];
    lane_byte = merge_lane(lane_ok, picked, dflt_byte);
  end
endmodule

// File: rtl/byte_table_lookup.sv
module byte_table_lookup
  import tlu_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ENTRY_W     = 64,
  parameter int LANES       = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [$clog2(NUM_ENTRIES)-1:0]  wr_addr,
  input  logic [ENTRY_W-1:0]              wr_data,
  input  logic [LANES*BYTE_W-1:0]         idx_word,
  input  logic [LANES*BYTE_W-1:0]         dflt_word,
  input  logic [BYTE_W-1:0]               limit,
  output logic [LANES*BYTE_W-1:0]         result
);
  localparam int TBL_W = NUM_ENTRIES * ENTRY_W;

  logic [TBL_W-1:0] table_flat;  // table contents, watched by the checker
  logic [LANES-1:0] lane_ok;     // per-lane range decision, watched by the checker

  tlu_table_store #(.NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .table_flat (table_flat)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    tlu_lane_pick #(.NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W)) u_pick (
      .idx_byte   (idx_word[k*BYTE_W +: BYTE_W]),
      .dflt_byte  (dflt_word[k*BYTE_W +: BYTE_W]),
      .limit      (limit),
      .table_flat (table_flat),
      .lane_byte  (result[k*BYTE_W +: BYTE_W]),
      .lane_ok    (lane_ok[k])
    );
  end
endmodule

// File: rtl/tlu_checker.sv
module tlu_checker
  import tlu_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ENTRY_W     = 64,
  parameter int LANES       = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [$clog2(NUM_ENTRIES)-1:0]  wr_addr,
  input logic [ENTRY_W-1:0]              wr_data,
  input logic [LANES*BYTE_W-1:0]         idx_word,
  input logic [LANES*BYTE_W-1:0]         dflt_word,
  input logic [BYTE_W-1:0]               limit,
  input logic [LANES*BYTE_W-1:0]         result,
  input logic [LANES-1:0]                lane_ok,
  input logic [NUM_ENTRIES*ENTRY_W-1:0]  table_flat
);
  localparam int CAP = NUM_ENTRIES * ENTRY_W / BYTE_W;

  logic                           past_ok;
  logic                           prev_en;
  logic [$clog2(NUM_ENTRIES)-1:0] prev_addr;
  logic [ENTRY_W-1:0]             prev_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok   <= 1'b0;
      prev_en   <= 1'b0;
      prev_addr <= '0;
      prev_data <= '0;
    end else begin
      past_ok   <= 1'b1;
      prev_en   <= wr_en;
      prev_addr <= wr_addr;
      prev_data <= wr_data;
    end
  end

  // R7: the table is all zero on the first edge that sees reset released
  a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (table_flat == '0));

  // R6: the addressed entry holds the written data one edge later
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && prev_en) |-> (table_flat[32'(prev_addr)*ENTRY_W +: ENTRY_W] == prev_data));

  // R9: with the enable low, the table does not move
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !prev_en) |-> $stable(table_flat));

  // R8: a zero limit admits no lane
  a_r8_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> (lane_ok == '0));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    // R2: indices at or beyond capacity never count as in range
    a_r2_far_index: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(idx_word[k*BYTE_W +: BYTE_W]) >= CAP) |-> !lane_ok[k]);
    // R4: rejected lanes show the default byte
    a_r4_default_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_ok[k] |-> (result[k*BYTE_W +: BYTE_W] == dflt_word[k*BYTE_W +: BYTE_W]));
  end
endmodule

bind byte_table_lookup tlu_checker #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .ENTRY_W     (ENTRY_W),
  .LANES       (LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .idx_word   (idx_word),
  .dflt_word  (dflt_word),
  .limit      (limit),
  .result     (result),
  .lane_ok    (lane_ok),
  .table_flat (table_flat)
);

// File: tb/byte_table_lookup_tb.sv
module byte_table_lookup_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [31:0] idx_word = '0;
  logic [31:0] dflt_word = '0;
  logic [7:0]  limit = '0;
  logic [31:0] result;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [7:0] model [32];  // byte-level image of the table

  byte_table_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .idx_word(idx_word), .dflt_word(dflt_word),
    .limit(limit), .result(result)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] pat_byte(input int e, input int b, input bit alt);
    int v;
    v = (e * 8 + b) * 7 + 3;
    if (alt) v = v ^ 8'hFF;
    return 8'(v);
  endfunction

  // R1/R2/R3/R4: expected word from the byte model, lane by lane
  function automatic logic [31:0] expect_word(input logic [31:0] iw,
                                              input logic [31:0] dw,
                                              input logic [7:0] lim);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      int v;
      v = int'(iw[8*k +: 8]);
      if (v < int'(lim) && v < 32) r[8*k +: 8] = model[v];
      else                         r[8*k +: 8] = dw[8*k +: 8];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    vectors++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s idx=%h dflt=%h limit=%0d actual=%h expected=%h",
               tag, idx_word, dflt_word, limit, result, exp);
    end
  endtask

  task automatic load_entry(input int e, input bit alt);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 2'(e);
    for (int b = 0; b < 8; b++) begin
      wr_data[8*b +: 8] = pat_byte(e, b, alt);
      model[e*8 + b]    = pat_byte(e, b, alt);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R5: vectors change every 2 time units with no clock edge needed
  task automatic sweep(input logic [7:0] lim, input string tag);
    limit = lim;
    for (int i = 0; i < 256; i++) begin
      idx_word  = {8'(255 - i), 8'(i * 3 + 5), 8'(i + 37), 8'(i)};
      dflt_word = {8'(i ^ 8'h3C), 8'(i + 99), 8'(~i), 8'(i ^ 8'hC3)};
      #2;
      check(tag, expect_word(idx_word, dflt_word, lim));
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 32; j++) model[j] = 8'h00;
    // R7: table reads zero while reset is held
    limit = 8'd32; idx_word = 32'h1F_10_08_00; dflt_word = 32'hDEADBEEF;
    #(CLK_P * 2 + 1);
    check("R7", 32'h0);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R7", 32'h0);

    // R6: fill every entry
    for (int e = 0; e < 4; e++) load_entry(e, 1'b0);

    // R9: a write request with the enable low is ignored
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 2'd1; wr_data = '1;
    @(negedge clk);
    limit = 8'd32; idx_word = 32'h0F_0C_0A_08; dflt_word = 32'h0;
    #1 check("R9", expect_word(idx_word, dflt_word, limit));

    sweep(8'd0,   "R8 R1");
    sweep(8'd8,   "R2 R3 R4");
    sweep(8'd16,  "R2 R3 R4");
    sweep(8'd24,  "R2 R3 R4");
    sweep(8'd32,  "R1 R3");
    sweep(8'd40,  "R2 capacity");
    sweep(8'd255, "R2 capacity");

    // R6: rewriting entry 2 leaves entries 0, 1 and 3 intact
    load_entry(2, 1'b1);
    sweep(8'd32, "R6 R3");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule